// File: doc/BRIEF.md
# Start-Up Option Fetch Sequencer

This block runs a small controller from reset to its first instruction fetch. When the active-low reset is released, it first counts out a fixed oscillator-settling interval. It then spends a fixed window of 512 clocks reading the 64 configuration bytes from the reserved top page of the 8 KB program memory. That page is page 127, addresses 0x1FC0 to 0x1FFF. Each byte goes into its own option register. These registers are exported as one flat vector and set pin types, edge polarities, serial bit order and clock dividers elsewhere in the chip.

While the sequencer owns the memory read port, fetch requests from the processor are held off. When the window closes, the block raises its run signal and pulses a program-counter load with the start address 0x0000. From then on, processor fetches pass straight through to the memory. Asserting reset at any point returns everything to the initial state.

Top module: `option_boot_loader`

## Requirements
- R1: While `rst_n` is low at a clock edge, after that edge `run`, `pc_load` and `mem_rd` are 0 and every bit of `opt_bytes` is 0.
- R2: For the first SETTLE_CYCLES (default 4096) clock edges after reset release, no memory read is issued and `run` stays 0.
- R3: The option-fetch window lasts exactly 512 clocks. `run` first reads 1 after SETTLE_CYCLES+512 edges have passed since reset release, and 0 one edge earlier.
- R4: The 64 option reads go to addresses 0x1FC0+i in ascending order of i. Read i is issued (`mem_rd`=1 for one cycle) in window cycle 8*i, and window cycle 0 follows the last settle edge. No other read happens in the window.
- R5: Memory reads have one cycle of latency: `mem_rdata` is valid after the edge that samples `mem_rd`. The byte read for index i appears on `opt_bytes[8*i+7:8*i]` two edges after its request is seen, and is 0 one edge after it.
- R6: While `run` is 0, `cpu_fetch_req` and `cpu_fetch_addr` have no effect on `mem_rd` or `mem_addr`.
- R7: In the first cycle with `run`=1, `pc_load` is 1 for exactly one cycle and `pc_start` is 0x0000.
- R8: Reset asserted mid-settle, mid-fetch or while running clears the option bytes and `run`. After the next release, the full settle interval is counted again before the first read.
- R9: Once `run` is 1 it stays 1 until reset. `mem_rd` equals `cpu_fetch_req` and, when it is set, `mem_addr` equals `cpu_fetch_addr` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cpu_fetch_req | input | 1 | Processor instruction fetch request |
| cpu_fetch_addr | input | 13 | Processor fetch address |
| mem_rdata | input | 8 | Read data from program memory, one cycle after request |
| mem_rd | output | 1 | Program memory read strobe |
| mem_addr | output | 13 | Program memory read address |
| opt_bytes | output | 512 | Latched option bytes, byte i at bits 8*i+7:8*i |
| run | output | 1 | Processor released |
| pc_load | output | 1 | One-cycle program-counter load pulse |
| pc_start | output | 13 | Program-counter start value (0x0000) |

## Verification
The bench counts edges from the release of reset. The first read strobe must be visible after exactly SETTLE_CYCLES edges. Read i must appear 8*i edges later. Each option byte must be zero one edge after its strobe is sampled and equal to the memory pattern one edge after that. `run` and the `pc_load` pulse are checked both at SETTLE_CYCLES+512 edges and one edge before. Every sample is taken 1 ns after a rising edge, so registered results are read between edges. The bench compares them against counts it derives independently, and memory data comes from a bench model with one-cycle latency.

// File: rtl/olseq_pkg.sv
package olseq_pkg;

    localparam int PM_ADDR_W   = 13;
    localparam int PM_DATA_W   = 8;
    localparam int PAGE_WORDS  = 64;
    localparam int CFG_PAGE    = 127;
    localparam int CFG_COUNT   = 64;
    localparam int SETTLE_DEF  = 4096;
    localparam int WINDOW_DEF  = 512;

    localparam logic [PM_ADDR_W-1:0] CFG_BASE = PM_ADDR_W'(CFG_PAGE * PAGE_WORDS);

    typedef enum logic [1:0] {
        PH_SETTLE = 2'd0,
        PH_FETCH  = 2'd1,
        PH_RUN    = 2'd2
    } phase_e;

    typedef struct packed {
        logic                 req;
        logic [PM_ADDR_W-1:0] addr;
    } rd_port_t;

    function automatic logic [PM_ADDR_W-1:0] cfg_addr(input logic [PM_ADDR_W-1:0] idx);
        return CFG_BASE + idx;
    endfunction

endpackage

// File: rtl/bootseq_ctrl.sv
module bootseq_ctrl
    import olseq_pkg::*;
#(
    parameter int SETTLE_CYC = SETTLE_DEF,
    parameter int WINDOW_CYC = WINDOW_DEF,
    parameter int OPT_N      = CFG_COUNT,
    parameter int IDX_W      = $clog2(OPT_N)
) (
    input  logic             clk,
    input  logic             rst_n,
    output phase_e           phase,
    output logic             rd_en,
    output logic [IDX_W-1:0] rd_idx,
    output logic             start_pulse
);

    localparam int CNT_TOP = (SETTLE_CYC > WINDOW_CYC) ? SETTLE_CYC : WINDOW_CYC;
    localparam int CNT_W   = (CNT_TOP > 1) ? $clog2(CNT_TOP) : 1;
    localparam int STEP    = WINDOW_CYC / OPT_N;
    localparam int SLOT_W  = (STEP > 1) ? $clog2(STEP) : 0;
    localparam logic [CNT_W-1:0] SETTLE_LAST = CNT_W'(SETTLE_CYC - 1);
    localparam logic [CNT_W-1:0] WINDOW_LAST = CNT_W'(WINDOW_CYC - 1);

    logic [CNT_W-1:0] cnt;
    logic             slot_zero;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase       <= PH_SETTLE;
            cnt         <= '0;
            start_pulse <= 1'b0;
        end else begin
            start_pulse <= 1'b0;
            case (phase)
                PH_SETTLE: begin
                    if (cnt == SETTLE_LAST) begin
                        phase <= PH_FETCH;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_FETCH: begin
                    if (cnt == WINDOW_LAST) begin
                        phase       <= PH_RUN;
                        cnt         <= '0;
                        start_pulse <= 1'b1;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_RUN:  cnt   <= cnt;
                default: phase <= PH_SETTLE;
            endcase
        end
    end

    generate
        if (SLOT_W == 0) begin : g_every
            assign slot_zero = 1'b1;
        end else begin : g_spaced
            assign slot_zero = (cnt[SLOT_W-1:0] == '0);
        end
    endgenerate

    assign rd_en  = (phase == PH_FETCH) && slot_zero;
    assign rd_idx = IDX_W'(cnt >> SLOT_W);

    // R3: the fetch phase is only ever entered from the settle phase
    a_r3_fetch_after_settle: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_FETCH && $past(phase) != PH_FETCH) |-> $past(phase) == PH_SETTLE);

    // R9: run phase holds until reset
    a_r9_run_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_RUN) |=> (phase == PH_RUN));

    // R7: load pulse only in the first run cycle
    a_r7_pulse_on_entry: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |-> (phase == PH_RUN && $past(phase) == PH_FETCH));

endmodule

// File: rtl/optbank.sv
module optbank #(
    parameter int OPT_N  = 64,
    parameter int DATA_W = 8,
    parameter int IDX_W  = $clog2(OPT_N)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    rd_issued,
    input  logic [IDX_W-1:0]        rd_idx,
    input  logic [DATA_W-1:0]       rd_data,
    output logic [OPT_N*DATA_W-1:0] bytes_flat
);

    logic             pend;
    logic [IDX_W-1:0] pend_idx;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend     <= 1'b0;
            pend_idx <= '0;
        end else begin
            pend     <= rd_issued;
            pend_idx <= rd_idx;
        end
    end

    generate
        for (genvar g = 0; g < OPT_N; g++) begin : g_byte
            logic [DATA_W-1:0] r;
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    r <= '0;
                end else if (pend && pend_idx == IDX_W'(g)) begin
                    r <= rd_data;
                end
            end
            assign bytes_flat[g*DATA_W +: DATA_W] = r;
        end
    endgenerate

    // R5: option bytes change only one edge after a pending capture
    a_r5_hold_without_capture: assert property (@(posedge clk) disable iff (!rst_n)
        !pend |=> $stable(bytes_flat));

endmodule

// File: rtl/fetch_portmux.sv
module fetch_portmux
    import olseq_pkg::*;
(
    input  logic     run,
    input  rd_port_t ld_port,
    input  rd_port_t cpu_port,
    output rd_port_t mem_port
);

    always_comb begin
        if (run) begin
            mem_port = cpu_port;
        end else begin
            mem_port = ld_port;
        end
    end

endmodule

// File: rtl/option_boot_loader.sv
module option_boot_loader
    import olseq_pkg::*;
#(
    parameter int SETTLE_CYCLES = SETTLE_DEF,
    parameter int WINDOW_CYCLES = WINDOW_DEF,
    parameter int OPT_N         = CFG_COUNT
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cpu_fetch_req,
    input  logic [PM_ADDR_W-1:0]       cpu_fetch_addr,
    input  logic [PM_DATA_W-1:0]       mem_rdata,
    output logic                       mem_rd,
    output logic [PM_ADDR_W-1:0]       mem_addr,
    output logic [OPT_N*PM_DATA_W-1:0] opt_bytes,
    output logic                       run,
    output logic                       pc_load,
    output logic [PM_ADDR_W-1:0]       pc_start
);

    localparam int IDX_W = $clog2(OPT_N);

    phase_e           phase;
    logic             ld_en;
    logic [IDX_W-1:0] ld_idx;
    rd_port_t         ld_port, cpu_port, mem_port;

    bootseq_ctrl #(
        .SETTLE_CYC (SETTLE_CYCLES),
        .WINDOW_CYC (WINDOW_CYCLES),
        .OPT_N      (OPT_N),
        .IDX_W      (IDX_W)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .phase       (phase),
        .rd_en       (ld_en),
        .rd_idx      (ld_idx),
        .start_pulse (pc_load)
    );

    optbank #(
        .OPT_N  (OPT_N),
        .DATA_W (PM_DATA_W),
        .IDX_W  (IDX_W)
    ) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_issued  (ld_en),
        .rd_idx     (ld_idx),
        .rd_data    (mem_rdata),
        .bytes_flat (opt_bytes)
    );

    assign run           = (phase == PH_RUN);
    assign ld_port.req   = ld_en;
    assign ld_port.addr  = cfg_addr(PM_ADDR_W'(ld_idx));
    assign cpu_port.req  = cpu_fetch_req;
    assign cpu_port.addr = cpu_fetch_addr;

    fetch_portmux u_mux (
        .run      (run),
        .ld_port  (ld_port),
        .cpu_port (cpu_port),
        .mem_port (mem_port)
    );

    assign mem_rd   = mem_port.req;
    assign mem_addr = mem_port.addr;
    assign pc_start = '0;

    // R1: reset leaves the block idle with cleared options
    a_r1_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (!run && !pc_load && !mem_rd && opt_bytes == '0));

    // R4 / R6: before release every memory read targets the option page
    a_r4_reads_in_option_page: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && mem_rd) |-> (mem_addr >= CFG_BASE));

    // R7: release always comes with the load pulse
    a_r7_release_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run) |-> pc_load);

    // R7: load pulse lasts a single cycle
    a_r7_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load |=> !pc_load);

endmodule

// File: tb/option_boot_loader_test.sv
module option_boot_loader_test;
    import olseq_pkg::*;

    localparam int S = 4096;
    localparam int W = 512;
    localparam int N = 64;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cpu_fetch_req = 1'b0;
    logic [12:0]  cpu_fetch_addr = '0;
    logic [7:0]   mem_rdata = '0;
    logic         mem_rd;
    logic [12:0]  mem_addr;
    logic [511:0] opt_bytes;
    logic         run;
    logic         pc_load;
    logic [12:0]  pc_start;

    int  tests = 0;
    int  fails = 0;
    bit  done  = 1'b0;
    logic [7:0] key = 8'hA5;

    always #4 clk = ~clk;

    option_boot_loader uut (
        .clk(clk), .rst_n(rst_n), .cpu_fetch_req(cpu_fetch_req),
        .cpu_fetch_addr(cpu_fetch_addr), .mem_rdata(mem_rdata),
        .mem_rd(mem_rd), .mem_addr(mem_addr), .opt_bytes(opt_bytes),
        .run(run), .pc_load(pc_load), .pc_start(pc_start)
    );

    function automatic logic [7:0] pat(input logic [12:0] a);
        return a[7:0] ^ key;
    endfunction

    always @(posedge clk) if (mem_rd) mem_rdata <= pat(mem_addr);

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    function automatic int nonzero_bytes();
        int n = 0;
        for (int i = 0; i < N; i++) if (opt_bytes[i*8 +: 8] != 8'h00) n++;
        return n;
    endfunction

    function automatic int pattern_misses();
        int n = 0;
        for (int i = 0; i < N; i++)
            if (opt_bytes[i*8 +: 8] !== pat(13'h1FC0 + 13'(i))) n++;
        return n;
    endfunction

    task automatic release_after_reset(input int n);
        rst_n = 1'b0;
        repeat (n) step();
        rst_n = 1'b1;
    endtask

    task automatic edges_to_first_read(output int n);
        n = 0;
        while (!mem_rd && n < S + 10) begin
            step();
            n++;
        end
    endtask

    task automatic t_reset_state();
        rst_n = 1'b0;
        cpu_fetch_req = 1'b1;
        cpu_fetch_addr = 13'h0040;
        repeat (3) step();
        chk("R1", "run in reset", 32'(run), 0);
        chk("R1", "pc_load in reset", 32'(pc_load), 0);
        chk("R1", "mem_rd in reset", 32'(mem_rd), 0);
        chk("R1", "nonzero option bytes", 32'(nonzero_bytes()), 0);
    endtask

    task automatic t_full_boot(input logic [7:0] k);
        int bad_settle = 0, rd_bad = 0, reads = 0, early = 0, late = 0, run_early = 0;
        key = k;
        cpu_fetch_req = 1'b1;
        cpu_fetch_addr = 13'h0123;
        release_after_reset(2);
        for (int s = 0; s < S; s++) begin
            if (mem_rd !== 1'b0 || run !== 1'b0) bad_settle++;
            step();
        end
        chk("R2", "reads or run during settle", 32'(bad_settle), 0);
        for (int j = 0; j < W; j++) begin
            bit want = (j % 8) == 0;
            if (run !== 1'b0) run_early++;
            if (mem_rd !== want) rd_bad++;
            if (mem_rd === 1'b1) begin
                reads++;
                if (mem_addr !== 13'h1FC0 + 13'(j / 8)) rd_bad++;
            end
            step();
            if (j % 8 == 0 && opt_bytes[(j/8)*8 +: 8] !== 8'h00) early++;
            if (j % 8 == 1 && opt_bytes[(j/8)*8 +: 8] !== pat(13'h1FC0 + 13'(j / 8))) late++;
        end
        chk("R6", "cpu request leaked or read slot wrong", 32'(rd_bad), 0);
        chk("R4", "option reads in window", 32'(reads), 64);
        chk("R5", "byte visible too early", 32'(early), 0);
        chk("R5", "byte missing after latency", 32'(late), 0);
        chk("R3", "run before window end", 32'(run_early), 0);
        chk("R3", "run at settle+512", 32'(run), 1);
        chk("R7", "pc_load at release", 32'(pc_load), 1);
        chk("R7", "pc_start value", 32'(pc_start), 0);
        chk("R5", "option pattern misses", 32'(pattern_misses()), 0);
        step();
        chk("R7", "pc_load one cycle only", 32'(pc_load), 0);
    endtask

    task automatic t_run_hold();
        int bad = 0;
        for (int k = 0; k < 40; k++) begin
            cpu_fetch_req = k[0];
            cpu_fetch_addr = 13'h0100 + 13'(k * 37);
            #1;
            if (run !== 1'b1) bad++;
            if (mem_rd !== cpu_fetch_req) bad++;
            if (cpu_fetch_req && mem_addr !== cpu_fetch_addr) bad++;
            if (pc_load !== 1'b0) bad++;
            step();
        end
        chk("R9", "passthrough or sticky run errors", 32'(bad), 0);
    endtask

    task automatic t_reset_in_run();
        rst_n = 1'b0;
        step();
        chk("R8", "run after reset in run", 32'(run), 0);
        chk("R8", "options cleared after reset in run", 32'(nonzero_bytes()), 0);
        chk("R1", "pc_load after reset in run", 32'(pc_load), 0);
    endtask

    task automatic t_reset_mid_settle();
        int n;
        release_after_reset(2);
        repeat (2000) step();
        rst_n = 1'b0;
        step();
        chk("R8", "run after mid-settle reset", 32'(run), 0);
        rst_n = 1'b1;
        edges_to_first_read(n);
        chk("R8", "settle restarts in full (settle reset)", 32'(n), 32'(S));
        chk("R4", "first read address", 32'(mem_addr), 32'h1FC0);
        repeat (W) step();
        chk("R3", "run after restarted boot", 32'(run), 1);
        chk("R5", "options after restarted boot", 32'(pattern_misses()), 0);
    endtask

    task automatic t_reset_mid_fetch();
        int n;
        release_after_reset(2);
        repeat (S + 100) step();
        chk("R5", "some bytes loaded mid-window", 32'(nonzero_bytes() > 0), 1);
        rst_n = 1'b0;
        step();
        chk("R8", "options cleared mid-fetch", 32'(nonzero_bytes()), 0);
        chk("R8", "mem_rd after mid-fetch reset", 32'(mem_rd), 0);
        rst_n = 1'b1;
        edges_to_first_read(n);
        chk("R8", "settle restarts in full (fetch reset)", 32'(n), 32'(S));
    endtask

    initial begin
        t_reset_state();
        t_full_boot(8'hA5);
        t_run_hold();
        t_reset_in_run();
        t_reset_mid_settle();
        t_reset_mid_fetch();
        t_full_boot(8'h3C);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(64'd200000 * 64'd8);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog R3 actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule